// File: doc/BRIEF.md
# Three-Phase Bridge Phase-Error Monitor

This block watches the three half-bridges of a motor driver and flags any phase whose switch node fails to follow its gate commands. Each phase supplies a high-side command, a low-side command and one comparator bit that reads high when the switch node is above half of the battery supply. After every turn-on of a gate command the block waits a programmed number of clock cycles, the dead time and blanking interval together, and then compares the synchronized node bit with what the command implies.

A failed high-side check means the node stayed low although the upper switch was driven. It is latched per phase and is also reported on a separate desaturation output. A failed low-side check means the node stayed high although the lower switch was driven. Per-phase results combine into a single fault signal, which sets a sticky status bit. The status bit drives an active-high interrupt when the enable input allows it. The interrupt drops only after a clear strobe arrives at a time when no fault remains.

Top module: `phase_err_monitor`

## Requirements
- R1: Each raw `node_hi` bit passes through two flip-flops before any check uses it. A check made at clock edge E sees the raw value that was sampled two edges before E.
- R2: Suppose `hs_cmd[p]` rises and is first sampled high at edge P0, with `dly_cnt` = D at P0. The high-side check is then made at edge P(max(D,1)), provided the command stays high throughout. If the synchronized node bit is 0 at that check, `phase_err[p]` reads 1 from the following cycle. A value of 0 in `dly_cnt` behaves as 1.
- R3: The same timing applies to `ls_cmd[p]`. The low-side check fails when the synchronized node bit is 1.
- R4: A check that passes clears the latched error of that side and phase. If the command falls before its check, no check takes place and the latched error does not change.
- R5: Every new rising edge of a command reloads that side's count from `dly_cnt`. The check timing then runs from the latest rising edge.
- R6: `phase_err[p]` is the OR of the high-side and low-side latched errors of phase p. `err_any` is the OR of all bits of `phase_err`.
- R7: `desat[p]` equals the latched high-side error of phase p. It never reflects a low-side error.
- R8: `err_status` becomes 1 on the edge after `err_any` is 1. It becomes 0 only on an edge where `clr_int` is 1 and `err_any` is 0. If `clr_int` is 1 while `err_any` is 1, setting wins.
- R9: `irq` equals `err_status` when `int_en` is 1. It is 0 when `int_en` is 0.
- R10: A synchronous active-low reset clears the synchronizer, all counters, all latched errors, `err_status` and `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hs_cmd | input | N_PH | High-side gate command per phase |
| ls_cmd | input | N_PH | Low-side gate command per phase |
| node_hi | input | N_PH | Raw comparator bit per phase: switch node above half supply |
| dly_cnt | input | CNT_W | Combined dead-time plus blanking count, in cycles |
| clr_int | input | 1 | Clear strobe for the status bit |
| int_en | input | 1 | Interrupt enable (mask) |
| phase_err | output | N_PH | Latched per-phase error |
| desat | output | N_PH | Latched high-side error per phase |
| err_any | output | 1 | OR of all per-phase errors |
| err_status | output | 1 | Sticky phase-error status bit |
| irq | output | 1 | Active-high interrupt |

## Verification
Directed patterns exercise each side separately:
- A high-side turn-on with the node held low, and a low-side turn-on with the node held high. These separate the two failure polarities and show that only the high side reaches `desat`.
- A command withdrawn early, and a command re-triggered mid-count. These show whether a check is skipped or its timing restarts.
- A node change placed one edge before and one edge after the synchronizer boundary. This exposes a wrong synchronizer depth.
- A clear strobe issued both while the fault persists and after it has gone. This separates set priority from a plain clear.

Seeded random toggling of commands, node bits, delay, clear, enable and reset is then compared every cycle against a bench model of the requirements.

// File: rtl/pem_pkg.sv
// Package: shared types for the phase-error monitor.
// Assumes: nothing; holds only the side selector.
package pem_pkg;
    typedef enum logic {SIDE_HIGH = 1'b0, SIDE_LOW = 1'b1} side_e;
endpackage

// File: rtl/pem_sync.sv
// Module: pem_sync
// Multi-stage synchronizer for a vector of asynchronous bits.
// Assumes: each bit is independent; the bits are not related as a bus.
module pem_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] stage_q [STAGES];

    // Shift the raw bits through STAGES flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d_in;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/pem_side_chk.sv
// Module: pem_side_chk
// Checks one gate (high or low side) of one phase.
// After each rising edge of the command, it waits dly cycles and then samples
// the node bit once. The result is latched until the next check.
// Assumes: node_hi is already synchronized; a dly of 0 behaves as 1.
module pem_side_chk
    import pem_pkg::*;
#(
    parameter int    CNT_W = 8,
    parameter side_e SIDE  = SIDE_HIGH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate_on,
    input  logic             node_hi,
    input  logic [CNT_W-1:0] dly,
    output logic             err
);
    logic             gate_q;
    logic             armed_q;
    logic             err_q;
    logic [CNT_W-1:0] cnt_q;
    logic             rise;
    logic             due;
    logic             miss;

    assign rise = gate_on & ~gate_q;
    assign due  = armed_q & gate_on & ~rise & (cnt_q <= CNT_W'(1));

    // Polarity of a failed check depends on which switch is driven.
    generate
        if (SIDE == SIDE_HIGH) begin : g_high
            assign miss = ~node_hi;
        end else begin : g_low
            assign miss = node_hi;
        end
    endgenerate

    // Edge detect, countdown and result latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q  <= 1'b0;
            armed_q <= 1'b0;
            err_q   <= 1'b0;
            cnt_q   <= '0;
        end else begin
            gate_q <= gate_on;
            if (rise) begin
                cnt_q   <= dly;
                armed_q <= 1'b1;
            end else if (armed_q && !gate_on) begin
                armed_q <= 1'b0;
            end else if (due) begin
                armed_q <= 1'b0;
                err_q   <= miss;
            end else if (armed_q) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    assign err = err_q;

    // R4
    withdrawn_no_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_on |=> $stable(err));

    // R5
    rise_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> (cnt_q == $past(dly)) && armed_q);
endmodule

// File: rtl/pem_phase.sv
// Module: pem_phase
// One bridge phase: a high-side checker and a low-side checker sharing the node bit.
// Assumes: node_hi is synchronized by the parent.
module pem_phase
    import pem_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hs_on,
    input  logic             ls_on,
    input  logic             node_hi,
    input  logic [CNT_W-1:0] dly,
    output logic             hs_err,
    output logic             ls_err,
    output logic             ph_err
);
    pem_side_chk #(.CNT_W(CNT_W), .SIDE(SIDE_HIGH)) i_hs (
        .clk(clk), .rst_n(rst_n), .gate_on(hs_on), .node_hi(node_hi),
        .dly(dly), .err(hs_err)
    );

    pem_side_chk #(.CNT_W(CNT_W), .SIDE(SIDE_LOW)) i_ls (
        .clk(clk), .rst_n(rst_n), .gate_on(ls_on), .node_hi(node_hi),
        .dly(dly), .err(ls_err)
    );

    assign ph_err = hs_err | ls_err;
endmodule

// File: rtl/phase_err_monitor.sv
// Module: phase_err_monitor (top)
// Monitors N_PH half-bridges for switch nodes that do not follow their gate
// commands. It keeps a sticky status bit and drives a maskable interrupt.
// Assumes: gate commands are synchronous to clk; node_hi is asynchronous.
module phase_err_monitor
    import pem_pkg::*;
#(
    parameter int N_PH        = 3,
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_PH-1:0]  hs_cmd,
    input  logic [N_PH-1:0]  ls_cmd,
    input  logic [N_PH-1:0]  node_hi,
    input  logic [CNT_W-1:0] dly_cnt,
    input  logic             clr_int,
    input  logic             int_en,
    output logic [N_PH-1:0]  phase_err,
    output logic [N_PH-1:0]  desat,
    output logic             err_any,
    output logic             err_status,
    output logic             irq
);
    logic [N_PH-1:0] node_s;
    logic [N_PH-1:0] ls_err;
    logic            status_q;

    pem_sync #(.W(N_PH), .STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .d_in(node_hi), .d_out(node_s)
    );

    // One checker pair per phase.
    generate
        for (genvar p = 0; p < N_PH; p++) begin : g_ph
            pem_phase #(.CNT_W(CNT_W)) i_ph (
                .clk(clk), .rst_n(rst_n),
                .hs_on(hs_cmd[p]), .ls_on(ls_cmd[p]), .node_hi(node_s[p]),
                .dly(dly_cnt),
                .hs_err(desat[p]), .ls_err(ls_err[p]), .ph_err(phase_err[p])
            );
        end
    endgenerate

    assign err_any = |phase_err;

    // Sticky status: the fault sets it, the strobe clears it, and setting wins.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= 1'b0;
        else        status_q <= err_any | (status_q & ~clr_int);
    end

    assign err_status = status_q;
    assign irq        = status_q & int_en;

    // R8
    status_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_any |=> err_status);

    // R8
    status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_status && clr_int && !err_any) |=> !err_status);

    // R9
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !int_en |-> !irq);

    // R7
    desat_implies_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (desat & ~phase_err) == '0);

    // R10
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> !err_status && !irq && (phase_err == '0));
endmodule

// File: tb/test_phase_err_monitor.sv
module test_phase_err_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 3;
    localparam int CW = 8;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic          rst_n;
    logic [N-1:0]  hs_cmd, ls_cmd, node_hi;
    logic [CW-1:0] dly_cnt;
    logic          clr_int, int_en;
    logic [N-1:0]  phase_err, desat;
    logic          err_any, err_status, irq;

    phase_err_monitor #(.N_PH(N), .CNT_W(CW), .SYNC_STAGES(2)) i_phase_err_monitor (
        .clk(clk), .rst_n(rst_n), .hs_cmd(hs_cmd), .ls_cmd(ls_cmd),
        .node_hi(node_hi), .dly_cnt(dly_cnt), .clr_int(clr_int), .int_en(int_en),
        .phase_err(phase_err), .desat(desat), .err_any(err_any),
        .err_status(err_status), .irq(irq)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // Bench model of the requirements; side 0 = high, side 1 = low.
    bit m_gq  [2][N];
    int m_cnt [2][N];
    bit m_arm [2][N];
    bit m_err [2][N];
    bit m_s1 [N];
    bit m_s2 [N];
    bit m_stat;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit m_any();
        bit a = 0;
        for (int p = 0; p < N; p++) a |= m_err[0][p] | m_err[1][p];
        return a;
    endfunction

    // Next state of the model as of the coming clock edge (R1-R10).
    task automatic model_next();
        bit any_now;
        if (!rst_n) begin
            for (int s = 0; s < 2; s++)
                for (int p = 0; p < N; p++) begin
                    m_gq[s][p] = 0; m_cnt[s][p] = 0; m_arm[s][p] = 0; m_err[s][p] = 0;
                end
            for (int p = 0; p < N; p++) begin m_s1[p] = 0; m_s2[p] = 0; end
            m_stat = 0;
            return;
        end
        any_now = m_any();
        for (int s = 0; s < 2; s++)
            for (int p = 0; p < N; p++) begin
                bit c;
                c = (s == 0) ? hs_cmd[p] : ls_cmd[p];
                if (c && !m_gq[s][p]) begin
                    m_cnt[s][p] = int'(dly_cnt); m_arm[s][p] = 1;
                end else if (m_arm[s][p] && !c) begin
                    m_arm[s][p] = 0;
                end else if (m_arm[s][p]) begin
                    if (m_cnt[s][p] <= 1) begin
                        m_arm[s][p] = 0;
                        m_err[s][p] = (s == 0) ? !m_s2[p] : m_s2[p];
                    end else m_cnt[s][p]--;
                end
                m_gq[s][p] = c;
            end
        m_stat = any_now | (m_stat & !clr_int);
        for (int p = 0; p < N; p++) begin m_s2[p] = m_s1[p]; m_s1[p] = node_hi[p]; end
    endtask

    task automatic compare();
        logic [N-1:0] e_pe, e_ds;
        for (int p = 0; p < N; p++) begin
            e_pe[p] = m_err[0][p] | m_err[1][p];
            e_ds[p] = m_err[0][p];
        end
        chk("R6 phase_err model", 32'(phase_err), 32'(e_pe));
        chk("R7 desat model", 32'(desat), 32'(e_ds));
        chk("R6 err_any model", 32'(err_any), 32'(|e_pe));
        chk("R8 err_status model", 32'(err_status), 32'(m_stat));
        chk("R9 irq model", 32'(irq), 32'(m_stat & int_en));
    endtask

    task automatic step();
        model_next();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        rst_n = 0; hs_cmd = '0; ls_cmd = '0; node_hi = '0;
        dly_cnt = 8'd4; clr_int = 0; int_en = 0;
        void'($urandom(32'd2718));
        steps(2);
        // R10 reset state
        chk("R10 phase_err after reset", 32'(phase_err), 0);
        chk("R10 irq after reset", 32'(irq), 0);
        rst_n = 1;
        steps(4);

        // R2: high-side miss, D=4, node low
        hs_cmd[0] = 1; steps(4);
        chk("R2 no error before expiry", 32'(phase_err[0]), 0);
        steps(1);
        chk("R2 hs miss latched", 32'(phase_err[0]), 1);
        chk("R7 desat on hs miss", 32'(desat[0]), 1);
        steps(1);
        chk("R8 status set", 32'(err_status), 1);
        chk("R9 irq masked", 32'(irq), 0);
        int_en = 1; steps(1);
        chk("R9 irq enabled", 32'(irq), 1);
        clr_int = 1; steps(1);
        chk("R8 set wins over clear", 32'(err_status), 1);
        clr_int = 0;

        // R4: a passing check clears the latch; status stays sticky
        node_hi[0] = 1; hs_cmd[0] = 0; steps(3);
        hs_cmd[0] = 1; steps(5);
        chk("R4 passing check clears", 32'(phase_err[0]), 0);
        steps(1);
        chk("R8 status sticky", 32'(err_status), 1);
        clr_int = 1; steps(1); clr_int = 0;
        chk("R8 cleared", 32'(err_status), 0);
        chk("R9 irq drops", 32'(irq), 0);
        hs_cmd[0] = 0; steps(2);

        // R3: low-side miss, D=2, node high
        dly_cnt = 8'd2; node_hi[2] = 1; steps(3);
        ls_cmd[2] = 1; steps(2);
        chk("R3 no ls error before expiry", 32'(phase_err[2]), 0);
        steps(1);
        chk("R3 ls miss latched", 32'(phase_err[2]), 1);
        chk("R7 no desat on ls miss", 32'(desat[2]), 0);
        ls_cmd[2] = 0; node_hi[2] = 0; steps(3);
        ls_cmd[2] = 1; steps(4); ls_cmd[2] = 0; steps(1);

        // R4: withdrawn before expiry, node low on phase 1
        dly_cnt = 8'd5; hs_cmd[1] = 1; steps(3);
        hs_cmd[1] = 0; steps(10);
        chk("R4 withdrawn no check", 32'(phase_err[1]), 0);

        // R5: restart on a new rising edge, D=6
        dly_cnt = 8'd6; hs_cmd[1] = 1; steps(3);
        hs_cmd[1] = 0; steps(1);
        hs_cmd[1] = 1; steps(6);
        chk("R5 not yet after restart", 32'(phase_err[1]), 0);
        steps(1);
        chk("R5 check after restart", 32'(phase_err[1]), 1);
        hs_cmd[1] = 0; steps(2);

        // R1: synchronizer depth, D=3, phase 0
        dly_cnt = 8'd3; node_hi[0] = 0; steps(3);
        hs_cmd[0] = 1; steps(1); node_hi[0] = 1; steps(3);
        chk("R1 node seen in time", 32'(phase_err[0]), 0);
        hs_cmd[0] = 0; node_hi[0] = 0; steps(3);
        hs_cmd[0] = 1; steps(2); node_hi[0] = 1; steps(2);
        chk("R1 node seen too late", 32'(phase_err[0]), 1);
        hs_cmd[0] = 0; steps(2);

        // Dly 0 behaves as 1 (R2)
        dly_cnt = 8'd0; node_hi[1] = 1; steps(3);
        hs_cmd[1] = 1; steps(2);
        chk("R2 zero delay passes", 32'(phase_err[1]), 0);
        hs_cmd[1] = 0; steps(1);

        // Random phase checked against the model
        for (int i = 0; i < 4000; i++) begin
            for (int p = 0; p < N; p++) begin
                if ($urandom_range(0, 7) == 0) hs_cmd[p] = ~hs_cmd[p];
                if ($urandom_range(0, 7) == 0) ls_cmd[p] = ~ls_cmd[p];
                if ($urandom_range(0, 11) == 0) node_hi[p] = ~node_hi[p];
            end
            if ($urandom_range(0, 19) == 0) dly_cnt = 8'($urandom_range(0, 6));
            clr_int = ($urandom_range(0, 9) == 0);
            if ($urandom_range(0, 29) == 0) int_en = ~int_en;
            rst_n = ($urandom_range(0, 499) != 0);
            step();
        end
        rst_n = 1;

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule